// File: doc/BRIEF.md
# Per-Port Traffic Key Vault

This block stores the 256-bit symmetric traffic keys used by a multi-port encryption datapath. Every client port (20 by default) has two independent keys: one for the transmit (encrypt) direction and one for the receive (decrypt) direction. Each key has a valid flag. The datapath may only encrypt or decrypt for a port while both of that port's keys are valid.

Host software loads a key in two steps. It first writes eight 32-bit words into a shared staging buffer. It then issues a commit strobe that names the port and the direction. The key and its valid flag change together, at the commit edge only, so a lookup never returns a key that is half old and half new. Host reads of key space always return zero; the stored key material has no path back to the host. A port can be zeroized when its service is torn down. An asynchronous reset zeroizes every port. A key can be replaced by committing a fresh one over it, which is how keys are rotated.

The datapath presents a port index on the lookup port. One cycle later it receives both keys of that port, their valid flags and a ready indication.

Top module: `port_key_vault`

## Requirements
- R1: While reset is asserted, and after it is released until the next commit, every lookup returns both keys as zero, both valid flags low and ready low.
- R2: Staging word k is held in key bits [32k+31:32k]. A commit with direction 0 stores the staged key as the encrypt key of the named port. A commit with direction 1 stores it as the decrypt key. The commit sets that key's valid flag.
- R3: A commit to one direction leaves the other direction's key and valid flag of the same port unchanged.
- R4: Writing staging words does not change any stored key. The new key becomes visible only after the commit edge.
- R5: A commit to a port that already holds a valid key replaces that key with the new one (rotation).
- R6: A zeroize request clears both keys of the named port to zero and drops both valid flags. Other ports are left unchanged.
- R7: If a zeroize request and a commit name the same port in the same cycle, the zeroize takes effect and the commit is discarded.
- R8: A host read strobe is acknowledged on the next cycle with read data of all zeros, whatever keys are stored.
- R9: The lookup result appears one cycle after the index is presented. Ready is high only when both the encrypt and the decrypt valid flags of the looked-up port are high.
- R10: Port indices at or above the port count are ignored by commit and by zeroize. A lookup of such an index returns zero keys, both valid flags low and ready low.
- R11: Every commit strobe clears the staging buffer. A commit that is not preceded by fresh staging writes therefore stores an all-zero key and marks it valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; zeroizes every port |
| stage_we_i | input | 1 | Staging word write strobe |
| stage_sel_i | input | 3 | Staging word index (0 = least significant word) |
| stage_wdata_i | input | 32 | Staging word data |
| commit_i | input | 1 | Commit the staged key |
| commit_dir_i | input | 1 | Commit direction: 0 encrypt, 1 decrypt |
| commit_port_i | input | 5 | Commit target port |
| zero_i | input | 1 | Zeroize request for one port |
| zero_port_i | input | 5 | Zeroize target port |
| rd_en_i | input | 1 | Host read strobe on key space |
| rd_ack_o | output | 1 | Host read acknowledge, one cycle after the strobe |
| rd_data_o | output | 32 | Host read data, always zero |
| lk_port_i | input | 5 | Datapath lookup port index |
| enc_key_o | output | 256 | Encrypt key of the looked-up port |
| enc_vld_o | output | 1 | Encrypt key valid |
| dec_key_o | output | 256 | Decrypt key of the looked-up port |
| dec_vld_o | output | 1 | Decrypt key valid |
| lk_ready_o | output | 1 | Port may carry traffic (both keys valid) |

## Verification
Two functions can act on the same port in the same cycle: a zeroize request from service removal and a key commit from rotation. The bench first loads a valid key pair on a port. It then raises the zeroize and commit strobes in one cycle, both naming that port, with a fresh nonzero key staged. A following lookup must show zero keys and low valid flags on both directions. The bench also puts a zeroize and a commit on different ports in one cycle, and both must take effect. In a separate case, a lookup presented in the same cycle as a commit must still return the old key.

// File: rtl/kv_pkg.sv
package kv_pkg;
  localparam int unsigned KEY_W  = 256;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned WORDS  = KEY_W / WORD_W;
  localparam int unsigned SEL_W  = $clog2(WORDS);

  typedef logic [KEY_W-1:0] key_t;

  typedef enum logic {
    DIR_ENC = 1'b0,
    DIR_DEC = 1'b1
  } dir_e;
endpackage

// File: rtl/kv_stage.sv
module kv_stage
  import kv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              clr_i,
  output key_t              key_o
);
  key_t stage_q;

  // clear beats write: key material never lingers past a commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stage_q <= '0;
    else if (clr_i) stage_q <= '0;
    else if (we_i)  stage_q[int'(sel_i)*WORD_W +: WORD_W] <= wdata_i;
  end

  assign key_o = stage_q;
endmodule

// File: rtl/kv_bank.sv
module kv_bank
  import kv_pkg::*;
#(
  parameter int unsigned NPORTS = 20,
  parameter int unsigned PORT_W = $clog2(NPORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [PORT_W-1:0] commit_port_i,
  input  key_t              key_i,
  input  logic              zero_i,
  input  logic [PORT_W-1:0] zero_port_i,
  input  logic [PORT_W-1:0] lk_port_i,
  output key_t              key_o,
  output logic              vld_o
);
  key_t key_q [NPORTS];
  logic [NPORTS-1:0] vld_q;
  logic lk_in_range;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NPORTS; p++) key_q[p] <= '0;
      vld_q <= '0;
    end else begin
      for (int p = 0; p < NPORTS; p++) begin
        if (zero_i && zero_port_i == PORT_W'(p)) begin
          key_q[p] <= '0;
          vld_q[p] <= 1'b0;
        end else if (commit_i && commit_port_i == PORT_W'(p)) begin
          key_q[p] <= key_i;
          vld_q[p] <= 1'b1;
        end
      end
    end
  end

  assign lk_in_range = {1'b0, lk_port_i} < (PORT_W+1)'(NPORTS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_o <= '0;
      vld_o <= 1'b0;
    end else if (lk_in_range) begin
      key_o <= key_q[lk_port_i];
      vld_o <= vld_q[lk_port_i];
    end else begin
      key_o <= '0;
      vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/port_key_vault.sv
module port_key_vault
  import kv_pkg::*;
#(
  parameter int unsigned NPORTS = 20,
  localparam int unsigned PORT_W = $clog2(NPORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stage_we_i,
  input  logic [SEL_W-1:0]  stage_sel_i,
  input  logic [WORD_W-1:0] stage_wdata_i,
  input  logic              commit_i,
  input  logic              commit_dir_i,
  input  logic [PORT_W-1:0] commit_port_i,
  input  logic              zero_i,
  input  logic [PORT_W-1:0] zero_port_i,
  input  logic              rd_en_i,
  output logic              rd_ack_o,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic [PORT_W-1:0] lk_port_i,
  output logic [KEY_W-1:0]  enc_key_o,
  output logic              enc_vld_o,
  output logic [KEY_W-1:0]  dec_key_o,
  output logic              dec_vld_o,
  output logic              lk_ready_o
);
  key_t staged;
  key_t bank_key [2];
  logic [1:0] bank_vld;

  kv_stage u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (stage_we_i),
    .sel_i   (stage_sel_i),
    .wdata_i (stage_wdata_i),
    .clr_i   (commit_i),
    .key_o   (staged)
  );

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic dir_commit;
    assign dir_commit = commit_i && (commit_dir_i == 1'(d));

    kv_bank #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_bank (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .commit_i      (dir_commit),
      .commit_port_i (commit_port_i),
      .key_i         (staged),
      .zero_i        (zero_i),
      .zero_port_i   (zero_port_i),
      .lk_port_i     (lk_port_i),
      .key_o         (bank_key[d]),
      .vld_o         (bank_vld[d])
    );
  end

  assign enc_key_o  = bank_key[DIR_ENC];
  assign enc_vld_o  = bank_vld[DIR_ENC];
  assign dec_key_o  = bank_key[DIR_DEC];
  assign dec_vld_o  = bank_vld[DIR_DEC];
  assign lk_ready_o = &bank_vld;

  // key space is write-only toward the host
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_ack_o <= 1'b0;
    else         rd_ack_o <= rd_en_i;
  end
  assign rd_data_o = '0;
endmodule

// File: rtl/kv_chk.sv
module kv_chk #(
  parameter int unsigned NPORTS = 20,
  parameter int unsigned PORT_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              zero_i,
  input logic [PORT_W-1:0] zero_port_i,
  input logic              rd_en_i,
  input logic              rd_ack_o,
  input logic [31:0]       rd_data_o,
  input logic [PORT_W-1:0] lk_port_i,
  input logic [255:0]      enc_key_o,
  input logic              enc_vld_o,
  input logic [255:0]      dec_key_o,
  input logic              dec_vld_o,
  input logic              lk_ready_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_clear_chk: assert (!enc_vld_o && !dec_vld_o && !lk_ready_o
                               && enc_key_o == '0 && dec_key_o == '0);
    end
  end

  // R8
  host_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rd_ack_o && rd_data_o == '0));

  // R10
  out_of_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, lk_port_i} >= (PORT_W+1)'(NPORTS))
    |=> (!enc_vld_o && !dec_vld_o && enc_key_o == '0 && dec_key_o == '0));

  // R6
  zeroize_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_i && ({1'b0, zero_port_i} < (PORT_W+1)'(NPORTS)))
    ##1 (lk_port_i == $past(zero_port_i))
    |=> (!enc_vld_o && !dec_vld_o && enc_key_o == '0 && dec_key_o == '0));

  // R9
  ready_needs_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_ready_o |-> (enc_vld_o && dec_vld_o));
endmodule

bind port_key_vault kv_chk #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .zero_i      (zero_i),
  .zero_port_i (zero_port_i),
  .rd_en_i     (rd_en_i),
  .rd_ack_o    (rd_ack_o),
  .rd_data_o   (rd_data_o),
  .lk_port_i   (lk_port_i),
  .enc_key_o   (enc_key_o),
  .enc_vld_o   (enc_vld_o),
  .dec_key_o   (dec_key_o),
  .dec_vld_o   (dec_vld_o),
  .lk_ready_o  (lk_ready_o)
);

// File: tb/port_key_vault_tb.sv
module port_key_vault_tb;
  localparam int NP = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic stage_we_i = 0;
  logic [2:0] stage_sel_i = '0;
  logic [31:0] stage_wdata_i = '0;
  logic commit_i = 0, commit_dir_i = 0;
  logic [4:0] commit_port_i = '0;
  logic zero_i = 0;
  logic [4:0] zero_port_i = '0;
  logic rd_en_i = 0;
  logic rd_ack_o;
  logic [31:0] rd_data_o;
  logic [4:0] lk_port_i = '0;
  logic [255:0] enc_key_o, dec_key_o;
  logic enc_vld_o, dec_vld_o, lk_ready_o;

  always #4 clk = ~clk;

  port_key_vault u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .stage_we_i(stage_we_i), .stage_sel_i(stage_sel_i), .stage_wdata_i(stage_wdata_i),
    .commit_i(commit_i), .commit_dir_i(commit_dir_i), .commit_port_i(commit_port_i),
    .zero_i(zero_i), .zero_port_i(zero_port_i),
    .rd_en_i(rd_en_i), .rd_ack_o(rd_ack_o), .rd_data_o(rd_data_o),
    .lk_port_i(lk_port_i),
    .enc_key_o(enc_key_o), .enc_vld_o(enc_vld_o),
    .dec_key_o(dec_key_o), .dec_vld_o(dec_vld_o), .lk_ready_o(lk_ready_o)
  );

  int n_chk = 0, n_bad = 0;

  // reference model
  logic [255:0] m_enc [NP];
  logic [255:0] m_dec [NP];
  bit m_ev [NP];
  bit m_dv [NP];
  logic [255:0] m_stage;

  typedef struct {
    logic [255:0] ek;
    logic [255:0] dk;
    bit ev;
    bit dv;
    string tag;
  } exp_t;
  exp_t sb_q[$];
  logic lk_req = 0, req_q = 0;

  function automatic logic [255:0] mk(int s);
    logic [255:0] k;
    for (int w = 0; w < 8; w++) k[w*32 +: 32] = (32'(s) * 32'h9E3779B1) ^ (32'(w + 1) * 32'h01010101);
    return k;
  endfunction

  task automatic model_clear();
    for (int p = 0; p < NP; p++) begin
      m_enc[p] = '0; m_dec[p] = '0; m_ev[p] = 0; m_dv[p] = 0;
    end
    m_stage = '0;
  endtask

  task automatic check(bit ok, string tag, string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // monitor: compares the result one cycle after each lookup
  always @(posedge clk) req_q <= lk_req;
  always @(negedge clk) begin
    if (req_q) begin
      if (sb_q.size() == 0) begin
        check(0, "R9", "lookup result with no expected item");
      end else begin
        exp_t e;
        bit ok;
        e = sb_q.pop_front();
        ok = (enc_key_o === e.ek) && (dec_key_o === e.dk) && (enc_vld_o === e.ev)
             && (dec_vld_o === e.dv) && (lk_ready_o === (e.ev && e.dv));
        check(ok, e.tag, $sformatf("act ek=%h ev=%b dk=%h dv=%b rdy=%b exp ek=%h ev=%b dk=%h dv=%b rdy=%b",
              enc_key_o, enc_vld_o, dec_key_o, dec_vld_o, lk_ready_o,
              e.ek, e.ev, e.dk, e.dv, e.ev && e.dv));
      end
    end
  end

  // all tasks start and end just after a falling edge
  task automatic lookup(int p, string tag);
    exp_t e;
    if (p < NP) begin
      e.ek = m_enc[p]; e.dk = m_dec[p]; e.ev = m_ev[p]; e.dv = m_dv[p];
    end else begin
      e.ek = '0; e.dk = '0; e.ev = 0; e.dv = 0;
    end
    e.tag = tag;
    sb_q.push_back(e);
    lk_port_i = 5'(p);
    lk_req = 1;
    @(negedge clk);
    lk_req = 0;
  endtask

  task automatic stage_key(logic [255:0] k);
    for (int w = 0; w < 8; w++) begin
      stage_we_i = 1; stage_sel_i = 3'(w); stage_wdata_i = k[w*32 +: 32];
      @(negedge clk);
    end
    stage_we_i = 0;
    m_stage = k;
  endtask

  task automatic commit(bit dir, int p);
    commit_i = 1; commit_dir_i = dir; commit_port_i = 5'(p);
    @(negedge clk);
    commit_i = 0;
    if (p < NP) begin
      if (dir) begin m_dec[p] = m_stage; m_dv[p] = 1; end
      else     begin m_enc[p] = m_stage; m_ev[p] = 1; end
    end
    m_stage = '0;
  endtask

  task automatic zeroize(int p);
    zero_i = 1; zero_port_i = 5'(p);
    @(negedge clk);
    zero_i = 0;
    if (p < NP) begin
      m_enc[p] = '0; m_dec[p] = '0; m_ev[p] = 0; m_dv[p] = 0;
    end
  endtask

  task automatic load(int p, int s);
    stage_key(mk(s));     commit(0, p);
    stage_key(mk(s + 1)); commit(1, p);
  endtask

  initial begin
    #(8ns * 150000);
    check(0, "WDOG", "act=timeout exp=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_clear();
    #2 rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1: reset state
    lookup(0, "R1");
    lookup(NP - 1, "R1");

    // R2 / R9: load port 4 both directions, one-cycle lookup
    load(4, 10);
    lookup(4, "R2");
    lookup(4, "R9");

    // R3: only encrypt on port 7 -> decrypt stays invalid, not ready
    stage_key(mk(30)); commit(0, 7);
    lookup(7, "R3");
    lookup(4, "R3");

    // R4 / R5: stage new key for port 4 enc, stored key unchanged until commit
    stage_key(mk(50));
    lookup(4, "R4");
    commit(0, 4);
    lookup(4, "R5");

    // R4: lookup in the same cycle as a commit still returns the old key
    stage_key(mk(60));
    begin
      exp_t e;
      e.ek = m_enc[4]; e.dk = m_dec[4]; e.ev = m_ev[4]; e.dv = m_dv[4]; e.tag = "R4";
      sb_q.push_back(e);
      lk_port_i = 5'd4; lk_req = 1;
      commit_i = 1; commit_dir_i = 1; commit_port_i = 5'd4;
      @(negedge clk);
      commit_i = 0; lk_req = 0;
      m_dec[4] = m_stage; m_dv[4] = 1; m_stage = '0;
    end
    lookup(4, "R5");

    // R11: commit with no fresh staging stores zero key, valid
    commit(1, 7);
    lookup(7, "R11");

    // R6: zeroize port 4, port 7 untouched
    zeroize(4);
    lookup(4, "R6");
    lookup(7, "R6");

    // R7: zeroize and commit same port same cycle
    load(9, 70);
    stage_key(mk(80));
    zero_i = 1; zero_port_i = 5'd9;
    commit_i = 1; commit_dir_i = 0; commit_port_i = 5'd9;
    @(negedge clk);
    zero_i = 0; commit_i = 0;
    m_enc[9] = '0; m_dec[9] = '0; m_ev[9] = 0; m_dv[9] = 0; m_stage = '0;
    lookup(9, "R7");

    // R7: zeroize and commit different ports same cycle, both apply
    stage_key(mk(90));
    zero_i = 1; zero_port_i = 5'd7;
    commit_i = 1; commit_dir_i = 0; commit_port_i = 5'd12;
    @(negedge clk);
    zero_i = 0; commit_i = 0;
    m_enc[7] = '0; m_dec[7] = '0; m_ev[7] = 0; m_dv[7] = 0;
    m_enc[12] = m_stage; m_ev[12] = 1; m_stage = '0;
    lookup(7, "R7");
    lookup(12, "R7");

    // R8: host read returns zero while keys are loaded
    load(19, 100);
    lookup(19, "R9");
    rd_en_i = 1;
    @(negedge clk);
    rd_en_i = 0;
    check(rd_ack_o === 1'b1 && rd_data_o === 32'h0, "R8",
          $sformatf("act ack=%b data=%h exp ack=1 data=0", rd_ack_o, rd_data_o));
    @(negedge clk);
    check(rd_ack_o === 1'b0, "R8", $sformatf("act ack=%b exp ack=0", rd_ack_o));

    // R10: out-of-range commit/zeroize ignored, lookup empty
    stage_key(mk(110)); commit(0, 25);
    zeroize(31);
    lookup(25, "R10");
    lookup(19, "R10");
    lookup(12, "R10");

    // R1: reset mid-run clears everything
    rst_ni = 0;
    @(negedge clk);
    rst_ni = 1;
    model_clear();
    @(negedge clk);
    lookup(19, "R1");
    lookup(12, "R1");

    @(negedge clk);
    @(negedge clk);
    check(sb_q.size() == 0, "R9", $sformatf("act pending=%0d exp pending=0", sb_q.size()));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule